// File: doc/BRIEF.md
# Audio Playback DMA FIFO

This block sits between an 8-bit DMA byte channel and a playback engine that consumes 16-bit stereo frames. Sample bytes arrive one at a time on a write strobe qualified by the DMA acknowledge. They are stored in a 16-byte buffer and delivered as a left/right pair on every sample tick. The block requests transfers in demand style and keeps its request asserted while there is room. It lowers the request one byte early, so a cycle that is already in flight still has a free slot. It also cuts any request burst that runs longer than a programmable number of clock cycles, which bounds how long the bus stays held (about 15 µs at the default).

Storage is arranged as four byte lanes. Lane k always holds the k-th byte of a frame, and frames leave the buffer only as complete four-byte units. When a tick finds fewer than four bytes, the outputs keep the previous frame and nothing is consumed. A starved stream therefore repeats audio and never swaps low and high bytes.

Top module: `audio_dma_fifo`

## Requirements
- R1: While reset is high and on the first sample after it, drq, frame_valid, underrun and overflow are 0 and both sample outputs are 0.
- R2: A byte is written only on a cycle where dack and wr_stb are both 1. wr_stb without dack, and dack without wr_stb, leave the buffer unchanged.
- R3: Bytes b0,b1,b2,b3 written in that order form one frame: left_out = {b1,b0} and right_out = {b3,b2}, with the low byte first. The frame appears, with a one-cycle frame_valid pulse, on the clock edge that samples sample_tick.
- R4: drq is a register. After any edge that leaves 15 or more bytes stored (DEPTH-1), drq is 0. After an edge that leaves fewer, and with no burst cut pending, drq is 1.
- R5: A sample_tick with fewer than 4 bytes stored consumes nothing. It raises underrun for one cycle and leaves left_out and right_out unchanged.
- R6: A qualified write while 16 bytes are stored is dropped. It sets the overflow flag on that edge, and the flag stays 1 until reset.
- R7: drq is never 1 for more than DRQ_LIMIT consecutive cycles. When a burst reaches the limit, drq goes to 0 for exactly one cycle and then follows the room rule again.
- R8: Frames come out in write order, including when the buffer pointers wrap.
- R9: A write and a frame-consuming tick on the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dack | input | 1 | DMA acknowledge, qualifies wr_stb |
| wr_stb | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte from the DMA channel |
| sample_tick | input | 1 | Request to present the next frame |
| drq | output | 1 | Demand-style DMA request |
| left_out | output | SAMPLE_W | Left sample of the current frame |
| right_out | output | SAMPLE_W | Right sample of the current frame |
| frame_valid | output | 1 | One-cycle pulse: a new frame was loaded |
| underrun | output | 1 | One-cycle pulse: tick found too few bytes, frame held |
| overflow | output | 1 | Sticky: a byte was dropped on a full buffer |

## Verification
The bench ticks with zero, two and then four bytes stored. A design that consumed partial frames would emit a shifted frame, and the scoreboard would catch it on the next frame. It fills the buffer to 15, 16 and 17 bytes to locate the exact cycle drq falls and the dropped byte. A design without headroom keeps drq high at 15, and one that accepted the 17th byte would corrupt the frames it drains across the pointer wrap. A write lands on the same cycle as a consuming tick, so a design that lost either event would misalign the next frame. The bench then measures a full drq burst against the limit, plus the single low cycle that follows it.

// File: rtl/audio_dma_pkg.sv
package audio_dma_pkg;
  localparam int BYTE_W        = 8;
  localparam int CH_PER_FRAME  = 2;
  localparam int DEF_DEPTH     = 16;
  localparam int DEF_SAMPLE_W  = 16;
  localparam int DEF_DRQ_LIMIT = 750;  // 15 us at 50 MHz
endpackage

// File: rtl/adf_lane_ram.sv
module adf_lane_ram #(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int ROWS = 1 << AW;

  logic [DW-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port; holds its value when not enabled
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/adf_drq_ctrl.sv
module adf_drq_ctrl #(
  parameter int LIMIT = 750
) (
  input  logic clk,
  input  logic rst,
  input  logic room,
  output logic drq
);
  localparam int RW = $clog2(LIMIT + 1);

  logic [RW-1:0] run;

  // run holds the number of earlier cycles in the current drq burst
  always_ff @(posedge clk) begin
    if (rst) begin
      drq <= 1'b0;
      run <= '0;
    end else if (drq && run == RW'(LIMIT - 1)) begin
      drq <= 1'b0;
      run <= '0;
    end else begin
      drq <= room;
      run <= (room && drq) ? run + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/audio_dma_fifo.sv
module audio_dma_fifo
  import audio_dma_pkg::*;
#(
  parameter int DEPTH     = DEF_DEPTH,
  parameter int SAMPLE_W  = DEF_SAMPLE_W,
  parameter int DRQ_LIMIT = DEF_DRQ_LIMIT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dack,
  input  logic                wr_stb,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                sample_tick,
  output logic                drq,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                frame_valid,
  output logic                underrun,
  output logic                overflow
);
  localparam int SPB = SAMPLE_W / BYTE_W;     // bytes per sample
  localparam int BPF = SPB * CH_PER_FRAME;    // bytes per frame
  localparam int LW  = $clog2(BPF);
  localparam int PW  = $clog2(DEPTH);
  localparam int AW  = PW - LW;
  localparam int CW  = $clog2(DEPTH + 1);

  logic [PW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_row;
  logic [CW-1:0]     level, level_nxt;
  logic              accept, pop, room;
  logic [BYTE_W-1:0] lane_q [BPF];

  assign accept = dack && wr_stb && (level != CW'(DEPTH));
  assign pop    = sample_tick && (level >= CW'(BPF));

  always_comb begin
    level_nxt = level;
    if (accept) level_nxt = level_nxt + 1'b1;
    if (pop)    level_nxt = level_nxt - CW'(BPF);
  end

  // leave one slot for a cycle already in flight
  assign room = level_nxt < CW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr      <= '0;
      rd_row      <= '0;
      level       <= '0;
      frame_valid <= 1'b0;
      underrun    <= 1'b0;
      overflow    <= 1'b0;
    end else begin
      level       <= level_nxt;
      frame_valid <= pop;
      underrun    <= sample_tick && !pop;
      if (accept) wr_ptr <= wr_ptr + 1'b1;
      if (pop)    rd_row <= rd_row + 1'b1;
      if (dack && wr_stb && !accept) overflow <= 1'b1;
    end
  end

  // one bank per byte position of a frame
  for (genvar g = 0; g < BPF; g++) begin : g_lane
    adf_lane_ram #(.AW(AW), .DW(BYTE_W)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .we    (accept && (wr_ptr[LW-1:0] == LW'(g))),
      .waddr (wr_ptr[PW-1:LW]),
      .wdata (wr_data),
      .re    (pop),
      .raddr (rd_row),
      .rdata (lane_q[g])
    );
  end

  for (genvar s = 0; s < SPB; s++) begin : g_pack
    assign left_out [s*BYTE_W +: BYTE_W] = lane_q[s];
    assign right_out[s*BYTE_W +: BYTE_W] = lane_q[SPB + s];
  end

  adf_drq_ctrl #(.LIMIT(DRQ_LIMIT)) u_drq (
    .clk  (clk),
    .rst  (rst),
    .room (room),
    .drq  (drq)
  );
endmodule

// File: rtl/adf_checker.sv
module adf_checker #(
  parameter int DEPTH     = 16,
  parameter int SAMPLE_W  = 16,
  parameter int DRQ_LIMIT = 750,
  parameter int CW        = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                drq,
  input logic                sample_tick,
  input logic                frame_valid,
  input logic                underrun,
  input logic                overflow,
  input logic [SAMPLE_W-1:0] left_out,
  input logic [SAMPLE_W-1:0] right_out,
  input logic [CW-1:0]       level
);
  localparam int HW = $clog2(DRQ_LIMIT + 2);

  logic [HW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst)      hi_run <= '0;
    else if (drq) hi_run <= hi_run + 1'b1;
    else          hi_run <= '0;
  end

  // R4
  drq_headroom_chk: assert property (@(posedge clk) disable iff (rst)
    (level >= CW'(DEPTH - 1)) |-> !drq);

  // R7
  drq_burst_chk: assert property (@(posedge clk) disable iff (rst)
    drq |-> (hi_run < HW'(DRQ_LIMIT)));

  // R3
  frame_source_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> $past(sample_tick));

  // R5
  hold_on_dry_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |-> ($stable(left_out) && $stable(right_out)));

  // R5
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(frame_valid && underrun));

  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R6
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));
endmodule

bind audio_dma_fifo adf_checker #(
  .DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W), .DRQ_LIMIT(DRQ_LIMIT), .CW($clog2(DEPTH + 1))
) u_chk (
  .clk(clk), .rst(rst), .drq(drq), .sample_tick(sample_tick),
  .frame_valid(frame_valid), .underrun(underrun), .overflow(overflow),
  .left_out(left_out), .right_out(right_out), .level(level)
);

// File: tb/audio_dma_fifo_test.sv
module audio_dma_fifo_test;
  localparam int LIM = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dack = 1'b0, wr_stb = 1'b0, sample_tick = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        drq, frame_valid, underrun, overflow;
  logic [15:0] left_out, right_out;

  int n_chk = 0, n_err = 0;
  logic [31:0] exp_q [$];
  logic [31:0] last_frame = '0;
  bit done = 0;

  always #10 clk = ~clk;

  audio_dma_fifo #(.DEPTH(16), .SAMPLE_W(16), .DRQ_LIMIT(LIM)) uut (
    .clk(clk), .rst(rst), .dack(dack), .wr_stb(wr_stb), .wr_data(wr_data),
    .sample_tick(sample_tick), .drq(drq), .left_out(left_out),
    .right_out(right_out), .frame_valid(frame_valid), .underrun(underrun),
    .overflow(overflow)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic write_byte(logic [7:0] b);
    dack = 1'b1; wr_stb = 1'b1; wr_data = b;
    @(negedge clk);
    dack = 1'b0; wr_stb = 1'b0;
  endtask

  task automatic send_frame(logic [7:0] b0, b1, b2, b3);
    write_byte(b0); write_byte(b1); write_byte(b2); write_byte(b3);
    exp_q.push_back({b3, b2, b1, b0});
  endtask

  task automatic tick();
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
  endtask

  // monitor / scoreboard (R3, R8)
  always @(negedge clk) begin
    if (!rst && frame_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected frame", {right_out, left_out}, 32'h0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk({right_out, left_out} == e, "R3/R8 frame", {right_out, left_out}, e);
        last_frame = {right_out, left_out};
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R1
    chk(drq == 1'b0, "R1 drq in reset", {31'b0, drq}, 32'h0);
    chk({right_out, left_out} == 32'h0, "R1 outputs in reset", {right_out, left_out}, 32'h0);
    chk({frame_valid, underrun, overflow} == 3'b0, "R1 flags in reset",
        {29'b0, frame_valid, underrun, overflow}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(overflow == 1'b0 && underrun == 1'b0, "R1 flags after reset",
        {30'b0, overflow, underrun}, 32'h0);
    @(negedge clk);
    chk(drq == 1'b1, "R4 drq with empty buffer", {31'b0, drq}, 32'h1);

    // R3 basic frame
    send_frame(8'h11, 8'h22, 8'h33, 8'h44);
    tick();
    chk(frame_valid == 1'b1, "R3 frame_valid pulse", {31'b0, frame_valid}, 32'h1);
    chk(left_out == 16'h2211, "R3 left low byte first", {16'h0, left_out}, 32'h2211);
    @(negedge clk);
    chk(frame_valid == 1'b0, "R3 pulse one cycle", {31'b0, frame_valid}, 32'h0);

    // R2 unqualified strobes ignored
    dack = 1'b0; wr_stb = 1'b1; wr_data = 8'hAA; @(negedge clk);
    dack = 1'b1; wr_stb = 1'b0; wr_data = 8'hBB; @(negedge clk);
    dack = 1'b0;
    send_frame(8'h01, 8'h02, 8'h03, 8'h04);
    tick();
    chk({right_out, left_out} == 32'h04030201, "R2 unqualified writes ignored",
        {right_out, left_out}, 32'h04030201);

    // R5 underrun with empty and partial buffer
    tick();
    chk(underrun == 1'b1, "R5 underrun when empty", {31'b0, underrun}, 32'h1);
    chk({right_out, left_out} == 32'h04030201, "R5 hold when empty",
        {right_out, left_out}, 32'h04030201);
    write_byte(8'h55); write_byte(8'h66);
    tick();
    chk(underrun == 1'b1, "R5 underrun with two bytes", {31'b0, underrun}, 32'h1);
    chk({right_out, left_out} == 32'h04030201, "R5 hold with two bytes",
        {right_out, left_out}, 32'h04030201);
    write_byte(8'h77); write_byte(8'h88);
    exp_q.push_back(32'h88776655);
    tick();
    chk(frame_valid == 1'b1 && left_out == 16'h6655, "R5 no partial consumption",
        {16'h0, left_out}, 32'h6655);

    // R4 / R6 / R8 fill, overflow and wrap
    for (int i = 0; i < 15; i++) write_byte(8'h40 + 8'(i));
    chk(drq == 1'b0, "R4 drq low at 15 bytes", {31'b0, drq}, 32'h0);
    write_byte(8'h4F);
    chk(drq == 1'b0 && overflow == 1'b0, "R4 16th byte accepted, drq low",
        {30'b0, drq, overflow}, 32'h0);
    write_byte(8'hEE);
    chk(overflow == 1'b1, "R6 overflow on 17th byte", {31'b0, overflow}, 32'h1);
    for (int f = 0; f < 4; f++)
      exp_q.push_back({8'h43 + 8'(4*f), 8'h42 + 8'(4*f), 8'h41 + 8'(4*f), 8'h40 + 8'(4*f)});
    tick();
    chk(drq == 1'b1, "R4 drq back on at 12 bytes", {31'b0, drq}, 32'h1);
    @(negedge clk); tick();
    @(negedge clk); tick();
    @(negedge clk); tick();
    @(negedge clk); tick();
    chk(underrun == 1'b1, "R8 dropped byte not stored", {31'b0, underrun}, 32'h1);
    chk(overflow == 1'b1, "R6 overflow sticky", {31'b0, overflow}, 32'h1);

    // R9 simultaneous write and pop
    send_frame(8'hA0, 8'hA1, 8'hA2, 8'hA3);
    sample_tick = 1'b1; dack = 1'b1; wr_stb = 1'b1; wr_data = 8'h90;
    @(negedge clk);
    sample_tick = 1'b0; dack = 1'b0; wr_stb = 1'b0;
    chk(frame_valid == 1'b1, "R9 pop with concurrent write", {31'b0, frame_valid}, 32'h1);
    write_byte(8'h91); write_byte(8'h92); write_byte(8'h93);
    exp_q.push_back(32'h93929190);
    tick();
    chk(left_out == 16'h9190, "R9 concurrent byte kept", {16'h0, left_out}, 32'h9190);
    tick();
    chk(underrun == 1'b1, "R9 exactly one frame consumed", {31'b0, underrun}, 32'h1);

    // R7 burst limit
    cnt = 0;
    while (drq == 1'b1 && cnt < 4*LIM) begin @(negedge clk); cnt++; end
    while (drq == 1'b0 && cnt < 8*LIM) begin @(negedge clk); cnt++; end
    cnt = 0;
    while (drq == 1'b1 && cnt < 4*LIM) begin @(negedge clk); cnt++; end
    chk(cnt == LIM, "R7 burst length", cnt, LIM);
    cnt = 0;
    while (drq == 1'b0 && cnt < 4*LIM) begin @(negedge clk); cnt++; end
    chk(cnt == 1, "R7 single low cycle", cnt, 32'h1);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all frames delivered", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule